// File: doc/BRIEF.md
# DRAM Clock-Enable Power State Tracker

This block watches the clock-enable level and the registered command of a DDR2 memory device at each rising clock edge. It follows the device through active power-down, precharge power-down and self refresh. Each move is decided from three things: the clock-enable level seen at the previous edge, the level at the present edge, and the command presented with it. The tracker also checks two timing rules. Clock enable must stay at a new level for a minimum number of edges, and the commands that follow a self-refresh exit are held back for a set number of clocks.

A memory controller model or a bus monitor uses the tracker to see which power state the device is in. It also shows when general commands and reads may be issued again, and it flags any sequence the device would not accept. After an illegal sequence the tracker holds a fault state until reset, which stands in for the power cycle and re-initialisation the device would then need.

The command bus is `{cs_n, ras_n, cas_n, we_n}`. With cs_n = 1 the code is DESELECT. With cs_n = 0, `ras_n,cas_n,we_n` decode as follows: 111 NOP, 011 ACTIVATE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH, 000 MODE-REGISTER and 110 reserved. The power state is encoded as 0 active, 1 active power-down, 2 precharge power-down, 3 self refresh and 4 fault.

Top module: `ckepwr_tracker`

## Requirements
- R1: After reset, pwr_state is 0, err_pulse is 0, and cmd_ready and rd_ready are both 1.
- R2: In state 0, a high-then-low clock enable with NOP or DESELECT and op_busy low moves to state 2 when banks_idle is 1 and to state 1 when banks_idle is 0.
- R3: In state 0, a high-then-low clock enable with REFRESH (code 0001), banks_idle 1 and op_busy 0 moves to state 3.
- R4: In states 1, 2 and 3, a low-then-low clock enable keeps the state whatever the command, banks_idle or op_busy.
- R5: In states 1, 2 and 3, a low-then-high clock enable with NOP or DESELECT returns to state 0. Any other command in that case moves to state 4.
- R6: A high-then-low clock enable in state 0 moves to state 4 in three cases: op_busy is 1, the command is neither NOP, DESELECT nor REFRESH, or the command is REFRESH while banks_idle is 0.
- R7: A change of clock enable moves to state 4 when the previous level was registered on fewer than CKE_MIN (default 3) consecutive edges.
- R8: If self refresh is exited at edge E, cmd_ready stays low until it rises after edge E+XS_CYC-1. Any command other than NOP or DESELECT at an edge before E+XS_CYC moves to state 4.
- R9: After a self-refresh exit at edge E, rd_ready rises after edge E+XSRD_CYC-1 (default XSRD_CYC 200). A READ at an earlier edge moves to state 4.
- R10: In state 0 with clock enable high then high, the reserved code 0110 moves to state 4. Legal commands keep state 0.
- R11: Entering state 4 raises err_pulse for exactly one cycle. State 4 holds, with cmd_ready and rd_ready low, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable level at this edge |
| cmd_bus | input | 4 | {cs_n, ras_n, cas_n, we_n} registered at this edge |
| banks_idle | input | 1 | All banks precharged |
| op_busy | input | 1 | Read, write, mode-register, precharge or refresh in progress |
| pwr_state | output | 3 | Current power state code |
| err_pulse | output | 1 | One-cycle flag on entering fault |
| cmd_ready | output | 1 | Non-read commands accepted at next edge |
| rd_ready | output | 1 | READ accepted at next edge |

## Verification
Each output of this block is registered, so a clock enable and command sampled at edge N show up on pwr_state, err_pulse and the ready flags right after edge N. The bench drives inputs on the falling edge and checks one time unit after the next rising edge. The two exit windows are counted in edges from the exit edge E. cmd_ready is expected to rise after edge E+XS_CYC-1 and rd_ready after edge E+XSRD_CYC-1, and the bench compares both flags after every edge of the window. The fault tests then look again one edge later to confirm that err_pulse has dropped and the fault state has held.

// File: rtl/ckepwr_pkg.sv
package ckepwr_pkg;

    typedef enum logic [2:0] {
        PS_ACTIVE   = 3'd0,
        PS_ACT_PD   = 3'd1,
        PS_PRE_PD   = 3'd2,
        PS_SELF_REF = 3'd3,
        PS_FAULT    = 3'd4
    } pwr_state_e;

    typedef enum logic [3:0] {
        CMD_DESEL, CMD_NOP, CMD_ACT, CMD_READ, CMD_WRITE,
        CMD_PRE, CMD_REF, CMD_MRS, CMD_RSVD
    } cmd_e;

    // {cs_n, ras_n, cas_n, we_n}
    function automatic cmd_e decode_cmd(input logic [3:0] bus);
        cmd_e c;
        if (bus[3]) c = CMD_DESEL;
        else begin
            case (bus[2:0])
                3'b111:  c = CMD_NOP;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_READ;
                3'b100:  c = CMD_WRITE;
                3'b010:  c = CMD_PRE;
                3'b001:  c = CMD_REF;
                3'b000:  c = CMD_MRS;
                default: c = CMD_RSVD;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_quiet(input cmd_e c);
        return (c == CMD_NOP) || (c == CMD_DESEL);
    endfunction

endpackage

// File: rtl/ckepwr_hold.sv
module ckepwr_hold #(
    parameter int CKE_MIN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    output logic cke_prev,
    output logic hold_viol
);
    localparam int CW = $clog2(CKE_MIN + 1);
    localparam logic [CW-1:0] SAT = CW'(CKE_MIN);

    logic [CW-1:0] run_cnt;

    assign hold_viol = (cke != cke_prev) && (run_cnt < SAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_prev <= 1'b1;
            run_cnt  <= SAT;
        end else begin
            cke_prev <= cke;
            if (cke != cke_prev) run_cnt <= CW'(1);
            else if (run_cnt < SAT) run_cnt <= run_cnt + CW'(1);
        end
    end
endmodule

// File: rtl/ckepwr_delay.sv
module ckepwr_delay #(
    parameter int CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    assign busy = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (start)   cnt <= LOAD;
        else if (busy)    cnt <= cnt - CW'(1);
    end
endmodule

// File: rtl/ckepwr_fsm.sv
module ckepwr_fsm
    import ckepwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cke,
    input  logic       cke_prev,
    input  logic       hold_viol,
    input  logic [3:0] cmd_bus,
    input  logic       banks_idle,
    input  logic       op_busy,
    input  logic       xs_busy,
    input  logic       rd_busy,
    output pwr_state_e state,
    output logic       err_q,
    output logic       sr_exit
);
    pwr_state_e nxt;
    logic       viol;
    cmd_e       c;
    logic       quiet;

    always_comb begin
        c       = decode_cmd(cmd_bus);
        quiet   = is_quiet(c);
        nxt     = state;
        viol    = 1'b0;
        sr_exit = 1'b0;
        case (state)
            PS_ACTIVE: begin
                if (!cke_prev) viol = 1'b1;
                else if (xs_busy && !quiet) viol = 1'b1;
                else if (!cke) begin
                    if (op_busy) viol = 1'b1;
                    else if (quiet) nxt = banks_idle ? PS_PRE_PD : PS_ACT_PD;
                    else if (c == CMD_REF && banks_idle) nxt = PS_SELF_REF;
                    else viol = 1'b1;
                end else begin
                    if (c == CMD_RSVD) viol = 1'b1;
                    else if (c == CMD_READ && rd_busy) viol = 1'b1;
                end
            end
            PS_ACT_PD, PS_PRE_PD, PS_SELF_REF: begin
                if (cke_prev) viol = 1'b1;
                else if (cke) begin
                    if (quiet) begin
                        nxt     = PS_ACTIVE;
                        sr_exit = (state == PS_SELF_REF);
                    end else viol = 1'b1;
                end
            end
            default: nxt = PS_FAULT;
        endcase
        if (hold_viol && state != PS_FAULT) viol = 1'b1;
        if (viol) begin
            nxt     = PS_FAULT;
            sr_exit = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_ACTIVE;
            err_q <= 1'b0;
        end else begin
            state <= nxt;
            err_q <= viol;
        end
    end
endmodule

// File: rtl/ckepwr_tracker.sv
module ckepwr_tracker
    import ckepwr_pkg::*;
#(
    parameter int CKE_MIN  = 3,
    parameter int XS_CYC   = 10,
    parameter int XSRD_CYC = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cke,
    input  logic [3:0] cmd_bus,
    input  logic       banks_idle,
    input  logic       op_busy,
    output logic [2:0] pwr_state,
    output logic       err_pulse,
    output logic       cmd_ready,
    output logic       rd_ready
);
    localparam int NTMR = 2;
    localparam int TMR_LEN [NTMR] = '{XS_CYC, XSRD_CYC};

    logic       cke_prev, hold_viol, sr_exit;
    logic [NTMR-1:0] tmr_busy;
    pwr_state_e state;

    ckepwr_hold #(.CKE_MIN(CKE_MIN)) u_hold (
        .clk(clk), .rst(rst), .cke(cke),
        .cke_prev(cke_prev), .hold_viol(hold_viol)
    );

    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
        ckepwr_delay #(.CYC(TMR_LEN[i])) u_dly (
            .clk(clk), .rst(rst), .start(sr_exit), .busy(tmr_busy[i])
        );
    end

    ckepwr_fsm u_fsm (
        .clk(clk), .rst(rst), .cke(cke), .cke_prev(cke_prev),
        .hold_viol(hold_viol), .cmd_bus(cmd_bus),
        .banks_idle(banks_idle), .op_busy(op_busy),
        .xs_busy(tmr_busy[0]), .rd_busy(tmr_busy[1]),
        .state(state), .err_q(err_pulse), .sr_exit(sr_exit)
    );

    assign pwr_state = state;
    assign cmd_ready = (state == PS_ACTIVE) && !tmr_busy[0];
    assign rd_ready  = (state == PS_ACTIVE) && !tmr_busy[1];
endmodule

// File: rtl/ckepwr_tracker_chk.sv
module ckepwr_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic       cke,
    input logic [3:0] cmd_bus,
    input logic [2:0] pwr_state,
    input logic       err_pulse,
    input logic       cmd_ready,
    input logic       rd_ready
);
    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        pwr_state == 3'd4 |=> pwr_state == 3'd4);

    assert_err_single_R11: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> !err_pulse);

    assert_fault_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        pwr_state == 3'd4 |-> (!cmd_ready && !rd_ready));

    assert_lowpower_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (pwr_state inside {3'd1, 3'd2, 3'd3}) && !cke |=> pwr_state == $past(pwr_state));

    assert_sref_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd3 && $past(pwr_state) == 3'd0) |-> ($past(cmd_bus) == 4'b0001 && !$past(cke)));

    assert_read_after_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> cmd_ready);
endmodule

bind ckepwr_tracker ckepwr_tracker_chk u_chk (
    .clk(clk), .rst(rst), .cke(cke), .cmd_bus(cmd_bus),
    .pwr_state(pwr_state), .err_pulse(err_pulse),
    .cmd_ready(cmd_ready), .rd_ready(rd_ready)
);

// File: tb/sim_ckepwr_tracker.sv
`timescale 1ns/1ps
module sim_ckepwr_tracker;
    localparam int XS   = 10;
    localparam int XSRD = 200;
    localparam logic [3:0] NOP = 4'b0111, DES = 4'b1111, ACT = 4'b0011,
        RD = 4'b0101, WR = 4'b0100, REF = 4'b0001, RSV = 4'b0110;

    // {cke, cmd[3:0], idle, busy, exp_state[2:0], exp_err}
    localparam int NV = 17;
    localparam logic [10:0] VEC [NV] = '{
        {1'b1, NOP, 1'b1, 1'b0, 3'd0, 1'b0},
        {1'b0, NOP, 1'b1, 1'b0, 3'd2, 1'b0},
        {1'b0, RD,  1'b1, 1'b0, 3'd2, 1'b0},
        {1'b0, NOP, 1'b1, 1'b0, 3'd2, 1'b0},
        {1'b1, DES, 1'b1, 1'b0, 3'd0, 1'b0},
        {1'b1, NOP, 1'b1, 1'b0, 3'd0, 1'b0},
        {1'b1, NOP, 1'b1, 1'b0, 3'd0, 1'b0},
        {1'b0, NOP, 1'b0, 1'b0, 3'd1, 1'b0},
        {1'b0, NOP, 1'b0, 1'b0, 3'd1, 1'b0},
        {1'b0, NOP, 1'b0, 1'b0, 3'd1, 1'b0},
        {1'b1, NOP, 1'b0, 1'b0, 3'd0, 1'b0},
        {1'b1, ACT, 1'b0, 1'b0, 3'd0, 1'b0},
        {1'b1, WR,  1'b0, 1'b0, 3'd0, 1'b0},
        {1'b0, REF, 1'b1, 1'b0, 3'd3, 1'b0},
        {1'b0, WR,  1'b1, 1'b0, 3'd3, 1'b0},
        {1'b0, NOP, 1'b1, 1'b1, 3'd3, 1'b0},
        {1'b1, NOP, 1'b1, 1'b0, 3'd0, 1'b0}
    };

    logic clk = 1'b0, rst = 1'b1, cke = 1'b1, banks_idle = 1'b1, op_busy = 1'b0;
    logic [3:0] cmd_bus = NOP;
    logic [2:0] pwr_state;
    logic err_pulse, cmd_ready, rd_ready;
    int checks = 0, errors = 0, cycles = 0;

    always #5 clk = ~clk;

    ckepwr_tracker #(.CKE_MIN(3), .XS_CYC(XS), .XSRD_CYC(XSRD)) u0 (
        .clk(clk), .rst(rst), .cke(cke), .cmd_bus(cmd_bus),
        .banks_idle(banks_idle), .op_busy(op_busy),
        .pwr_state(pwr_state), .err_pulse(err_pulse),
        .cmd_ready(cmd_ready), .rd_ready(rd_ready)
    );

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: run did not finish");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    task automatic check(input string tag, input logic [2:0] es, input logic ee,
                         input logic ec, input logic er);
        checks++;
        if (pwr_state !== es || err_pulse !== ee || cmd_ready !== ec || rd_ready !== er) begin
            errors++;
            $display("FAIL %s: got state=%0d err=%b cr=%b rr=%b, expected state=%0d err=%b cr=%b rr=%b",
                     tag, pwr_state, err_pulse, cmd_ready, rd_ready, es, ee, ec, er);
        end
    endtask

    task automatic step(input logic k, input logic [3:0] c, input logic idle, input logic bz);
        @(negedge clk);
        cke = k; cmd_bus = c; banks_idle = idle; op_busy = bz;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cke = 1'b1; cmd_bus = NOP; banks_idle = 1'b1; op_busy = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic fault_then_hold(input string tag);
        check(tag, 3'd4, 1'b1, 1'b0, 1'b0);
        step(1'b1, NOP, 1'b1, 1'b0);
        check({tag, " R11 sticky"}, 3'd4, 1'b0, 1'b0, 1'b0);
    endtask

    // enter self refresh and leave it; returns right after exit edge E
    task automatic sref_cycle();
        step(1'b0, REF, 1'b1, 1'b0);
        step(1'b0, NOP, 1'b1, 1'b0);
        step(1'b0, NOP, 1'b1, 1'b0);
        step(1'b1, NOP, 1'b1, 1'b0);
    endtask

    initial begin
        do_reset();
        check("R1 reset", 3'd0, 1'b0, 1'b1, 1'b1);

        // table walk: R2 R3 R4 R5 R10
        for (int i = 0; i < NV; i++) begin
            logic [10:0] v;
            logic lp;
            v = VEC[i];
            step(v[10], v[9:6], v[5], v[4]);
            lp = (v[3:1] == 3'd0) && (i != NV-1);
            check($sformatf("R2/R3/R4/R5/R10 vector %0d", i), v[3:1], v[0],
                  (i == NV-1) ? 1'b0 : lp, (i == NV-1) ? 1'b0 : lp);
        end

        // exit windows after self refresh: R8 R9
        for (int k = 1; k <= XSRD; k++) begin
            logic [3:0] c;
            c = (k == XS) ? ACT : (k == XSRD) ? RD : NOP;
            step(1'b1, c, 1'b1, 1'b0);
            check($sformatf("R8/R9 exit window k=%0d", k), 3'd0, 1'b0,
                  (k >= XS-1), (k >= XSRD-1));
        end

        // R8 early command
        do_reset();
        sref_cycle();
        for (int k = 1; k < XS-1; k++) step(1'b1, DES, 1'b1, 1'b0);
        step(1'b1, ACT, 1'b1, 1'b0);
        fault_then_hold("R8 early ACT");
        do_reset();
        check("R1 reset after fault", 3'd0, 1'b0, 1'b1, 1'b1);

        // R9 early read
        sref_cycle();
        for (int k = 1; k < XS; k++) step(1'b1, NOP, 1'b1, 1'b0);
        step(1'b1, RD, 1'b1, 1'b0);
        fault_then_hold("R9 early READ");

        // R7 short clock-enable pulse
        do_reset();
        step(1'b0, NOP, 1'b1, 1'b0);
        check("R7 enter", 3'd2, 1'b0, 1'b0, 1'b0);
        step(1'b1, NOP, 1'b1, 1'b0);
        fault_then_hold("R7 short low");

        // R6 entry while busy
        do_reset();
        step(1'b0, NOP, 1'b1, 1'b1);
        fault_then_hold("R6 busy entry");

        // R6 entry with a write
        do_reset();
        step(1'b0, WR, 1'b1, 1'b0);
        fault_then_hold("R6 write entry");

        // R6 refresh with open banks
        do_reset();
        step(1'b0, REF, 1'b0, 1'b0);
        fault_then_hold("R6 refresh not idle");

        // R5 exit with a non-quiet command
        do_reset();
        step(1'b0, NOP, 1'b0, 1'b0);
        step(1'b0, NOP, 1'b0, 1'b0);
        step(1'b0, NOP, 1'b0, 1'b0);
        check("R5 in active power-down", 3'd1, 1'b0, 1'b0, 1'b0);
        step(1'b1, ACT, 1'b0, 1'b0);
        fault_then_hold("R5 bad exit");

        // R10 reserved code
        do_reset();
        step(1'b1, RSV, 1'b1, 1'b0);
        fault_then_hold("R10 reserved");

        do_reset();
        check("R1 final reset", 3'd0, 1'b0, 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule